// File: doc/BRIEF.md
# Dual Performance Event Counter Unit

This block keeps two 40-bit event counters for performance measurement. Each counter picks one hardware event through a 6-bit code held in a shared control word. It either sums the event's per-clock count, which is 0 to 2 for each code, or counts the clocks during which that event is active. Counting can be limited to privileged levels (0 to 2), to the user level (3), or to both. Each counter can hold a dedicated overflow pin high after its 40-bit value wraps.

Event sources arrive on a flat bus that carries one lane set per counter, so a code can mean one event on counter 0 and another on counter 1. Software reaches the control word and both counter values through a small single-cycle register port. Writing a counter reloads its value and drops its overflow pin.

Each counter has its own two-state overflow machine. `OVF_LOW` is the reset state. The transition *wrap-arm* moves it to `OVF_HELD` when the counter wraps while its overflow enable is set. The transition *reload-clear* returns it to `OVF_LOW` when software writes that counter. In every other case the machine stays where it is.

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset, every register address reads zero and both overflow pins are low.
- R2: The register address selects what is read and written. Address 0 is the control word. Address 1 is counter 0 and address 2 is counter 1, each 40 bits. Address 3 reads zero and ignores writes. Reads are combinational.
- R3: Control word layout: counter k uses bits starting at 16*k. Bits [5:0] hold the event code, [6] duration mode, [7] kernel enable, [8] user enable and [9] overflow enable. Bits outside these fields read back as zero.
- R4: In count mode, each clock a counter adds the 2-bit lane value of its selected code. A lane value of 2 adds 2 in one clock, and a lane value of 3 is treated as 2.
- R5: In duration mode, a counter adds exactly 1 in each clock whose selected lane value is nonzero.
- R6: With the kernel enable set, counting happens at privilege levels 0, 1 and 2. With the user enable set, counting happens at level 3. With only one of the two set, the other levels do not count.
- R7: With neither privilege enable set, counting happens at all four levels.
- R8: Counter k takes its events only from its own lane set. The lane for code c on counter k is evt_bus[(k*64+c)*2 +: 2].
- R9: Some codes are undefined and never change the counter. On both counters these are 0x10, 0x11, 0x20, 0x21 and 0x3C to 0x3F. Code 0x39 is also undefined on counter 1.
- R10: A counter with overflow enable set raises its overflow pin when it wraps past all ones, whether it adds 1 or 2. The pin is high in the same cycle as the wrapped value and stays high until software writes that counter.
- R11: A counter wraps modulo 2^40. When overflow enable is clear, a wrap leaves the pin low.
- R12: A software write to a counter wins over an event increment in the same cycle. The write also clears that counter's overflow pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data, combinational from reg_addr |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| evt_bus | input | 256 | Per-counter, per-code event counts, 2 bits each |
| ovf_pin | output | 2 | Overflow pin, one per counter |

## Verification
The bench sweeps all 64 codes on both counters. In each step the selected lane carries 2, the other lanes of that counter carry 1, and the other counter's lanes carry 0. This separates correct selection, wrong-code selection, cross-counter wiring and the undefined codes. Lane values 0 to 3 are applied in both modes, which separates summing, clamping and clock counting. The four privilege-enable combinations are tried at all four levels to confirm the filter's truth table. Near-all-ones preloads with increments of 1 and 2 exercise the wrap, the pin hold and the pin clear. A write that lands in the same cycle as an event shows which one wins.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int PMU_CODE_W   = 6;
    localparam int PMU_LAST_DEF = 'h3B;

    typedef struct packed {
        logic                  ovf_en;
        logic                  user_en;
        logic                  kern_en;
        logic                  dur_mode;
        logic [PMU_CODE_W-1:0] code;
    } ctr_cfg_t;

    localparam int PMU_CFG_W = $bits(ctr_cfg_t);

    typedef enum logic {
        OVF_LOW  = 1'b0,
        OVF_HELD = 1'b1
    } ovf_state_e;

    // Returns 1 when the code names an event source on the given counter.
    function automatic logic code_defined(input int unsigned ctr,
                                          input logic [PMU_CODE_W-1:0] c);
        logic ok;
        ok = 1'b1;
        if (int'(c) > PMU_LAST_DEF)                    ok = 1'b0;
        if (c == 6'h10 || c == 6'h11)                  ok = 1'b0;
        if (c == 6'h20 || c == 6'h21)                  ok = 1'b0;
        if (ctr == 1 && c == 6'h39)                    ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 2,
    parameter int CNT_W   = 40,
    parameter int ADDR_W  = 2,
    parameter int SLOT_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  ctr_cfg_t [NUM_CTR-1:0]            cfg_wdata,
    input  logic [NUM_CTR-1:0][CNT_W-1:0]     cnt_all,
    output ctr_cfg_t [NUM_CTR-1:0]            cfg_q,
    output logic [NUM_CTR-1:0]                cnt_wr,
    output logic [CNT_W-1:0]                  rdata
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    logic ctrl_wr;
    logic [CNT_W-1:0] ctrl_word;

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_wr) begin
            cfg_q <= cfg_wdata;
        end
    end

    generate
        for (genvar k = 0; k < NUM_CTR; k++) begin : g_dec
            assign cnt_wr[k] = wr_en && (addr == ADDR_W'(k + 1));
        end
    endgenerate

    always_comb begin
        ctrl_word = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            ctrl_word[k*SLOT_W +: PMU_CFG_W] = cfg_q[k];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) rdata = ctrl_word;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (addr == ADDR_W'(k + 1)) rdata = cnt_all[k];
        end
    end

    // R2: a control write is visible on the next cycle
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> cfg_q == $past(cfg_wdata));

    // R2: at most one counter decode per write
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr, cnt_wr}));

endmodule

// File: rtl/pmu_evt_select.sv
module pmu_evt_select
    import pmu_pkg::*;
#(
    parameter int CTR_IDX   = 0,
    parameter int NUM_CODES = 64
) (
    input  logic [2*NUM_CODES-1:0]  lane_bus,
    input  ctr_cfg_t                cfg,
    input  logic [1:0]              priv_lvl,
    output logic                    code_ok,
    output logic [1:0]              inc
);

    localparam logic [1:0] USER_LVL = 2'd3;

    logic [1:0] raw;
    logic [1:0] clamped;
    logic       at_user;
    logic       priv_ok;

    assign code_ok = code_defined(CTR_IDX, cfg.code);
    assign raw     = lane_bus[{cfg.code, 1'b0} +: 2];
    assign clamped = (raw == 2'd3) ? 2'd2 : raw;
    assign at_user = (priv_lvl == USER_LVL);

    always_comb begin
        if (!cfg.kern_en && !cfg.user_en) begin
            priv_ok = 1'b1;
        end else begin
            priv_ok = (cfg.kern_en && !at_user) || (cfg.user_en && at_user);
        end
    end

    always_comb begin
        inc = 2'd0;
        if (code_ok && priv_ok) begin
            if (cfg.dur_mode) inc = (raw != 2'd0) ? 2'd1 : 2'd0;
            else              inc = clamped;
        end
    end

    // R4: never more than two per clock
    always_comb begin
        a_inc_range_r4: assert (inc != 2'd3);
    end

endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
    import pmu_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       inc,
    input  logic             ovf_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pin
);

    logic [CNT_W:0] sum;
    logic           wrap;
    ovf_state_e     state_q, state_d;

    assign sum  = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
    assign wrap = sum[CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_hit) cnt_q <= wr_data;
        else             cnt_q <= sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_LOW:  if (!wr_hit && wrap && ovf_en) state_d = OVF_HELD;
            OVF_HELD: if (wr_hit)                    state_d = OVF_LOW;
            default:  state_d = OVF_LOW;
        endcase
    end

    always_comb begin
        ovf_pin = 1'b0;
        unique case (state_q)
            OVF_LOW:  ovf_pin = 1'b0;
            OVF_HELD: ovf_pin = 1'b1;
            default:  ovf_pin = 1'b0;
        endcase
    end

    // R12: software write wins
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> cnt_q == $past(wr_data));

    // R12: write clears the pin
    p_write_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !ovf_pin);

    // R10: pin holds until a write
    p_pin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pin && !wr_hit) |=> ovf_pin);

    // R10: pin only rises on a wrap with enable set
    p_pin_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pin) |-> ($past(ovf_en) && (cnt_q < $past(cnt_q))));

    // R4: step bound without a write
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> (cnt_q - $past(cnt_q)) <= CNT_W'(2));

endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 2,
    parameter int CNT_W   = 40,
    parameter int ADDR_W  = 2,
    parameter int SLOT_W  = 16,
    localparam int NUM_CODES = 1 << PMU_CODE_W,
    localparam int BUS_W     = NUM_CTR * NUM_CODES * 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [1:0]         priv_lvl,
    input  logic [BUS_W-1:0]   evt_bus,
    output logic [NUM_CTR-1:0] ovf_pin
);

    ctr_cfg_t [NUM_CTR-1:0]        cfg_wdata;
    ctr_cfg_t [NUM_CTR-1:0]        cfg_q;
    logic [NUM_CTR-1:0]            cnt_wr;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CTR-1:0][1:0]       inc;
    logic [NUM_CTR-1:0]            code_ok;

    generate
        for (genvar k = 0; k < NUM_CTR; k++) begin : g_wslot
            assign cfg_wdata[k] = reg_wdata[k*SLOT_W +: PMU_CFG_W];
        end
    endgenerate

    pmu_ctrl_regs #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .SLOT_W  (SLOT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .cfg_wdata (cfg_wdata),
        .cnt_all   (cnt_all),
        .cfg_q     (cfg_q),
        .cnt_wr    (cnt_wr),
        .rdata     (reg_rdata)
    );

    generate
        for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
            pmu_evt_select #(
                .CTR_IDX   (k),
                .NUM_CODES (NUM_CODES)
            ) u_sel (
                .lane_bus (evt_bus[k*NUM_CODES*2 +: NUM_CODES*2]),
                .cfg      (cfg_q[k]),
                .priv_lvl (priv_lvl),
                .code_ok  (code_ok[k]),
                .inc      (inc[k])
            );

            pmu_counter_slice #(
                .CNT_W (CNT_W)
            ) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (cnt_wr[k]),
                .wr_data (reg_wdata),
                .inc     (inc[k]),
                .ovf_en  (cfg_q[k].ovf_en),
                .cnt_q   (cnt_all[k]),
                .ovf_pin (ovf_pin[k])
            );

            // R9: undefined code leaves the counter untouched
            p_undef_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!code_ok[k] && !cnt_wr[k]) |=> $stable(cnt_all[k]));

            // R5: duration mode steps by at most one
            p_dur_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[k].dur_mode && !cnt_wr[k]) |=>
                    (cnt_all[k] - $past(cnt_all[k])) <= CNT_W'(1));

            // R6: kernel-only blocks the user level
            p_priv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[k].kern_en && !cfg_q[k].user_en && priv_lvl == 2'd3
                 && !cnt_wr[k]) |=> $stable(cnt_all[k]));
        end
    endgenerate

endmodule

// File: tb/tb_pmu_dual_counter.sv
`timescale 1ns/1ps
module tb_pmu_dual_counter;

    localparam int CW = 40;
    localparam int NC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic [1:0]    priv_lvl = 2'd0;
    logic [255:0]  evt_bus = '0;
    logic [1:0]    ovf_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pmu_dual_counter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_lvl(priv_lvl),
        .evt_bus(evt_bus), .ovf_pin(ovf_pin)
    );

    task automatic chk(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit defined(input int k, input int c);
        if (c > 'h3B) return 0;
        if (c == 'h10 || c == 'h11 || c == 'h20 || c == 'h21) return 0;
        if (k == 1 && c == 'h39) return 0;
        return 1;
    endfunction

    function automatic logic [CW-1:0] cfg_word(input int k, input int code, input bit dur,
                                              input bit kern, input bit usr, input bit ovf);
        logic [CW-1:0] w;
        w = '0;
        w[k*16 +: 10] = {ovf, usr, kern, dur, 6'(code)};
        return w;
    endfunction

    task automatic set_lane(input int k, input int c, input logic [1:0] v);
        evt_bus[(k*NC + c)*2 +: 2] = v;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [CW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // preload counter k, apply pat for one clock, return the value
    task automatic one_cycle(input int k, input logic [CW-1:0] base,
                             input logic [255:0] pat, output logic [CW-1:0] got);
        evt_bus = '0;
        wr_reg(2'(k + 1), base);
        evt_bus = pat;
        @(posedge clk);
        @(negedge clk);
        evt_bus = '0;
        rd_reg(2'(k + 1), got);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] v, base;
        logic [255:0] pat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk(v == '0, "R1 reset read", v, '0);
        end
        chk(ovf_pin == 2'b00, "R1 reset pins", CW'(ovf_pin), '0);

        // R3: control readback masks unused bits
        wr_reg(2'd0, {CW{1'b1}});
        rd_reg(2'd0, v);
        chk(v == 40'h00_03FF_03FF, "R3 ctrl readback", v, 40'h00_03FF_03FF);

        // R2: address 3 reads zero and ignores writes
        wr_reg(2'd0, '0);
        wr_reg(2'd1, 40'h55);
        wr_reg(2'd2, 40'h66);
        wr_reg(2'd3, 40'hAB_CDEF_0123);
        rd_reg(2'd3, v);
        chk(v == '0, "R2 addr3 read", v, '0);
        rd_reg(2'd1, v);
        chk(v == 40'h55, "R2 addr3 write no effect c0", v, 40'h55);
        rd_reg(2'd2, v);
        chk(v == 40'h66, "R2 addr3 write no effect c1", v, 40'h66);
        rd_reg(2'd0, v);
        chk(v == '0, "R2 addr3 write no effect ctrl", v, '0);

        // R8 R9 R4: sweep all codes on both counters
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < NC; c++) begin
                wr_reg(2'd0, cfg_word(k, c, 0, 0, 0, 0));
                pat = '0;
                for (int j = 0; j < NC; j++) pat[(k*NC + j)*2 +: 2] = 2'd1;
                pat[(k*NC + c)*2 +: 2] = 2'd2;
                base = 40'h12_3456_7800 + CW'(c);
                one_cycle(k, base, pat, v);
                chk(v == base + (defined(k, c) ? CW'(2) : CW'(0)),
                    "R8 R9 code sweep", v, base + (defined(k, c) ? CW'(2) : CW'(0)));
            end
        end

        // R4 R5: lane values in count and duration modes
        for (int d = 0; d < 2; d++) begin
            for (int lv = 0; lv < 4; lv++) begin
                logic [CW-1:0] e;
                wr_reg(2'd0, cfg_word(0, 'h1F, d[0], 0, 0, 0));
                pat = '0;
                pat[(0*NC + 'h1F)*2 +: 2] = 2'(lv);
                one_cycle(0, 40'h100, pat, v);
                if (d == 1) e = 40'h100 + ((lv != 0) ? CW'(1) : CW'(0));
                else        e = 40'h100 + ((lv == 3) ? CW'(2) : CW'(lv));
                chk(v == e, d ? "R5 duration" : "R4 count", v, e);
            end
        end

        // R6 R7: privilege truth table on counter 1, code 0x2A
        for (int ku = 0; ku < 4; ku++) begin
            for (int lvl = 0; lvl < 4; lvl++) begin
                bit kn, us, en;
                logic [CW-1:0] e;
                kn = ku[0]; us = ku[1];
                en = (!kn && !us) || (kn && lvl != 3) || (us && lvl == 3);
                wr_reg(2'd0, cfg_word(1, 'h2A, 0, kn, us, 0));
                priv_lvl = 2'(lvl);
                pat = '0;
                pat[(1*NC + 'h2A)*2 +: 2] = 2'd1;
                one_cycle(1, 40'h200, pat, v);
                e = 40'h200 + (en ? CW'(1) : CW'(0));
                chk(v == e, (!kn && !us) ? "R7 no qualifier" : "R6 privilege", v, e);
            end
        end
        priv_lvl = 2'd0;

        // R10: wrap by 2 from all-ones minus one sets the pin
        wr_reg(2'd0, cfg_word(0, 'h05, 0, 0, 0, 1) | cfg_word(1, 'h05, 0, 0, 0, 0));
        pat = '0;
        pat[(0*NC + 'h05)*2 +: 2] = 2'd2;
        one_cycle(0, 40'hFF_FFFF_FFFE, pat, v);
        chk(v == '0, "R10 wrap value", v, '0);
        chk(ovf_pin[0] == 1'b1, "R10 pin set", CW'(ovf_pin[0]), 1);
        repeat (3) @(negedge clk);
        chk(ovf_pin[0] == 1'b1, "R10 pin held", CW'(ovf_pin[0]), 1);
        wr_reg(2'd1, 40'h7);
        chk(ovf_pin[0] == 1'b0, "R12 write clears pin", CW'(ovf_pin[0]), 0);
        rd_reg(2'd1, v);
        chk(v == 40'h7, "R12 reload value", v, 40'h7);

        // R10: wrap by 2 from all-ones lands on 1
        one_cycle(0, 40'hFF_FFFF_FFFF, pat, v);
        chk(v == 40'h1, "R10 wrap by two", v, 40'h1);
        chk(ovf_pin[0] == 1'b1, "R10 pin set by two", CW'(ovf_pin[0]), 1);
        wr_reg(2'd1, '0);

        // R11: wrap without enable on counter 1
        pat = '0;
        pat[(1*NC + 'h05)*2 +: 2] = 2'd1;
        one_cycle(1, 40'hFF_FFFF_FFFF, pat, v);
        chk(v == '0, "R11 modulo wrap", v, '0);
        chk(ovf_pin[1] == 1'b0, "R11 pin stays low", CW'(ovf_pin[1]), 0);

        // R12: write in the same cycle as an event
        evt_bus = '0;
        set_lane(0, 'h05, 2'd2);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 40'h300;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        evt_bus = '0;
        rd_reg(2'd1, v);
        chk(v == 40'h300, "R12 write wins", v, 40'h300);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule